// File: doc/BRIEF.md
# SHA-256 Block Fetch Sequencer

This block is the control front end of a SHA-256 accelerator that takes its message straight from a shared local data memory. Software programs a byte-wide register port with a start address and a count of 64-byte blocks. It then issues a single execute command. From there the block owns the memory. It reads each 64-byte block as sixteen 32-bit words with one cycle of read latency, and converts each word from the memory's byte order to the big-endian word order the compression core expects. It hands the assembled block to the compression core through a start/done handshake, and fetches the next block only after the core reports done.

A separate command stores the core's eight-word hash state back to memory at the programmed address. A run can ask the core to restart from the standard initial hash values, or it can continue from the current state across several runs. When a run or a write-back ends, the block returns memory ownership to the CPU and sets a sticky completion flag. Software clears the flag by writing 1 to it, and an enable bit routes the flag to an interrupt line. The round logic and message padding sit outside this block.

Top module: `sha_fetch_ctrl`

## Requirements
- R1: After reset, all five registers read 0, busy and the completion flag are clear, `memOwn` is low (CPU owns memory) and `irq` is low.
- R2: Register map: offset 0 is control, with bit 0 execute, bit 1 initial-value reload, bit 2 write-back, and bits 6:4 an algorithm select that reads back and drives `coreAlgSel` as {bit6,bit5,bit4}. Bits 2:0 of control always read 0. Offset 1 is status, with bit 0 busy, bit 2 completion flag and bit 3 interrupt enable. Offset 2 holds the block count in its low bits. Offset 3 keeps only bits 7:6 (address bits 7:6). Offset 4 holds address bits 15:8.
- R3: An execute with count N reads 16*(N+1) words at consecutive word addresses, starting at word address {addr[15:6],4'b0}. Block b, word w is read from word address base + 16*b + w.
- R4: Byte order: bits 7:0 of a memory word are the first message byte and become bits 31:24 of the core word. Word w of a block sits at `coreBlock[511-32*w -: 32]`.
- R5: `coreStart` is a one-cycle pulse issued once all sixteen words of a block have been captured. No memory read for the next block occurs before `coreDone`. The run issues exactly N+1 pulses.
- R6: `coreInit` is high with the first block's `coreStart` only when execute and reload were written together. It is low for every other block and for any execute written without reload.
- R7: Write-back (bit 2 without bit 0) writes eight words to word addresses base..base+7. Word i is H_i, taken from `coreState[255-32*i -: 32]` with H0 highest, stored byte-swapped so that its bits 31:24 land in memory bits 7:0.
- R8: Busy and `memOwn` rise on the edge that accepts a command and stay high until the operation ends. `memRdEn` and `memWrEn` are only asserted while `memOwn` is high.
- R9: The completion flag is set when a run or a write-back ends. Writing 1 to status bit 2 clears it, writing 0 leaves it, and a set in the same cycle as a clear wins.
- R10: `irq` is high exactly when the completion flag and the interrupt enable are both set.
- R11: While busy, writes to control, count and both address registers are ignored: no new command starts and readback is unchanged. When execute and write-back are written together, only the execute runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational on regAddr) |
| memOwn | output | 1 | 1 = engine owns the shared memory |
| memAddr | output | 14 | Memory word address |
| memRdEn | output | 1 | Memory read request, data one cycle later |
| memRdData | input | 32 | Memory read data |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 32 | Memory write data |
| coreStart | output | 1 | Compression start pulse |
| coreInit | output | 1 | Reload initial hash values with this block |
| coreAlgSel | output | 3 | Algorithm select from control bits 6:4 |
| coreBlock | output | 512 | Sixteen big-endian message words |
| coreState | input | 256 | Core hash state H0..H7 |
| coreDone | input | 1 | Compression finished pulse |
| irq | output | 1 | Interrupt |

## Verification
Runs use random block counts, random base addresses and random reload choices. Each memory word is a distinct function of its address, so any wrong address, word slot or byte lane shows up in the assembled block. Directed runs cover the single-block and sixteen-block extremes, a write-back with a random hash state, and execute written together with write-back. Further directed cases write to the registers while busy and run the status clear-versus-enable sequence. These tell apart the register protection, the command priority and the flag and interrupt behaviour.

// File: rtl/sha_fetch_pkg.sv
package sha_fetch_pkg;
  localparam int ADDR_W  = 16;
  localparam int WADDR_W = ADDR_W - 2;
  localparam int WORD_W  = 32;
  localparam int BLK_WORDS  = 16;
  localparam int HASH_WORDS = 8;

  localparam logic [2:0] OFF_CTRL  = 3'd0;
  localparam logic [2:0] OFF_STAT  = 3'd1;
  localparam logic [2:0] OFF_COUNT = 3'd2;
  localparam logic [2:0] OFF_BASLO = 3'd3;
  localparam logic [2:0] OFF_BASHI = 3'd4;

  typedef struct packed {
    logic clrCnt;
    logic rdWord;
    logic nextBlk;
    logic wbWord;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_LAST  = 3'd2,
    ST_START = 3'd3,
    ST_WAIT  = 3'd4,
    ST_WB    = 3'd5
  } seqState_t;

  function automatic logic [WORD_W-1:0] byteSwap(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/sha_fetch_datapath.sv
module sha_fetch_datapath
  import sha_fetch_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobe_t                     strb,
  input  logic [ADDR_W-1:6]             baseAddr,
  input  logic [CNT_W-1:0]              blkCount,
  output logic [WADDR_W-1:0]            memAddr,
  output logic                          memRdEn,
  input  logic [WORD_W-1:0]             memRdData,
  output logic                          memWrEn,
  output logic [WORD_W-1:0]             memWrData,
  output logic [BLK_WORDS*WORD_W-1:0]   coreBlock,
  input  logic [HASH_WORDS*WORD_W-1:0]  coreState,
  output logic                          wordLast,
  output logic                          wbLast,
  output logic                          blkLast
);
  localparam int WIDX_W = $clog2(BLK_WORDS);
  localparam int HIDX_W = $clog2(HASH_WORDS);

  logic [WIDX_W-1:0]  wordIdx;
  logic [CNT_W-1:0]   blkIdx;
  logic               rdPend;
  logic [WIDX_W-1:0]  rdIdx;
  logic [WORD_W-1:0]  blockWords [BLK_WORDS];
  logic [WORD_W-1:0]  hashWords  [HASH_WORDS];
  logic [WADDR_W-1:0] baseWord;
  logic [WADDR_W-1:0] blkOffset;

  // word counter and block counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordIdx <= '0;
      blkIdx  <= '0;
    end else if (strb.clrCnt) begin
      wordIdx <= '0;
      blkIdx  <= '0;
    end else if (strb.nextBlk) begin
      wordIdx <= '0;
      blkIdx  <= blkIdx + 1'b1;
    end else if (strb.rdWord || strb.wbWord) begin
      wordIdx <= wordIdx + 1'b1;
    end
  end

  // one-cycle read latency tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPend <= 1'b0;
      rdIdx  <= '0;
    end else begin
      rdPend <= strb.rdWord;
      rdIdx  <= wordIdx;
    end
  end

  generate
    for (genvar i = 0; i < BLK_WORDS; i++) begin : g_blk
      always_ff @(posedge clk) begin
        if (!rstN) blockWords[i] <= '0;
        else if (rdPend && rdIdx == WIDX_W'(i)) blockWords[i] <= byteSwap(memRdData);
      end
      assign coreBlock[BLK_WORDS*WORD_W-1-WORD_W*i -: WORD_W] = blockWords[i];
    end
    for (genvar j = 0; j < HASH_WORDS; j++) begin : g_hash
      assign hashWords[j] = coreState[HASH_WORDS*WORD_W-1-WORD_W*j -: WORD_W];
    end
  endgenerate

  assign baseWord  = {baseAddr, 4'b0000};
  assign blkOffset = WADDR_W'({blkIdx, {WIDX_W{1'b0}}});
  assign memAddr   = baseWord + blkOffset + WADDR_W'(wordIdx);
  assign memRdEn   = strb.rdWord;
  assign memWrEn   = strb.wbWord;
  assign memWrData = byteSwap(hashWords[wordIdx[HIDX_W-1:0]]);

  assign wordLast = (wordIdx == WIDX_W'(BLK_WORDS - 1));
  assign wbLast   = (wordIdx == WIDX_W'(HASH_WORDS - 1));
  assign blkLast  = (blkIdx == blkCount);

  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && $past(memRdEn)) |-> (memAddr == WADDR_W'($past(memAddr) + 1'b1))); // R3
  AST_WB_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn)) |-> (memAddr == WADDR_W'($past(memAddr) + 1'b1))); // R7
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn)); // R8
endmodule

// File: rtl/sha_fetch_control.sv
module sha_fetch_control
  import sha_fetch_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output dpStrobe_t         strb,
  output logic [ADDR_W-1:6] baseAddr,
  output logic [CNT_W-1:0]  blkCount,
  input  logic              wordLast,
  input  logic              wbLast,
  input  logic              blkLast,
  output logic              coreStart,
  output logic              coreInit,
  output logic [2:0]        coreAlgSel,
  input  logic              coreDone,
  output logic              memOwn,
  output logic              irq
);
  seqState_t   state, stateNx;
  logic [2:0]  selReg;
  logic [CNT_W-1:0] cntReg;
  logic [1:0]  baseLo;
  logic [7:0]  baseHi;
  logic        ieReg, flagReg, initPend;
  logic        busy, cfgWr, execCmd, wbCmd, setFlag, statWr;

  assign busy    = (state != ST_IDLE);
  assign cfgWr   = regWrEn && !busy;
  assign execCmd = cfgWr && regAddr == OFF_CTRL && regWrData[0];
  assign wbCmd   = cfgWr && regAddr == OFF_CTRL && regWrData[2] && !regWrData[0];
  assign statWr  = regWrEn && regAddr == OFF_STAT;

  // sequencer next state and strobes
  always_comb begin
    stateNx   = state;
    strb      = '0;
    coreStart = 1'b0;
    setFlag   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (execCmd) begin
          stateNx = ST_FETCH; strb.clrCnt = 1'b1;
        end else if (wbCmd) begin
          stateNx = ST_WB; strb.clrCnt = 1'b1;
        end
      end
      ST_FETCH: begin
        strb.rdWord = 1'b1;
        if (wordLast) stateNx = ST_LAST;
      end
      ST_LAST:  stateNx = ST_START;
      ST_START: begin
        coreStart = 1'b1;
        stateNx   = ST_WAIT;
      end
      ST_WAIT: begin
        if (coreDone) begin
          if (blkLast) begin
            stateNx = ST_IDLE; setFlag = 1'b1;
          end else begin
            stateNx = ST_FETCH; strb.nextBlk = 1'b1;
          end
        end
      end
      ST_WB: begin
        strb.wbWord = 1'b1;
        if (wbLast) begin
          stateNx = ST_IDLE; setFlag = 1'b1;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      initPend <= 1'b0;
    end else begin
      state <= stateNx;
      if (execCmd) initPend <= regWrData[1];
      else if (strb.nextBlk) initPend <= 1'b0;
    end
  end

  // configuration registers, protected while busy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg <= '0;
      cntReg <= '0;
      baseLo <= '0;
      baseHi <= '0;
    end else if (cfgWr) begin
      unique case (regAddr)
        OFF_CTRL:  selReg <= regWrData[6:4];
        OFF_COUNT: cntReg <= regWrData[CNT_W-1:0];
        OFF_BASLO: baseLo <= regWrData[7:6];
        OFF_BASHI: baseHi <= regWrData;
        default: ;
      endcase
    end
  end

  // status: enable and write-1-to-clear completion flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ieReg   <= 1'b0;
      flagReg <= 1'b0;
    end else begin
      if (statWr) ieReg <= regWrData[3];
      if (setFlag) flagReg <= 1'b1;
      else if (statWr && regWrData[2]) flagReg <= 1'b0;
    end
  end

  always_comb begin
    unique case (regAddr)
      OFF_CTRL:  regRdData = {1'b0, selReg, 4'b0000};
      OFF_STAT:  regRdData = {4'b0000, ieReg, flagReg, 1'b0, busy};
      OFF_COUNT: regRdData = {{(8-CNT_W){1'b0}}, cntReg};
      OFF_BASLO: regRdData = {baseLo, 6'b000000};
      OFF_BASHI: regRdData = baseHi;
      default:   regRdData = 8'h00;
    endcase
  end

  assign baseAddr   = {baseHi, baseLo};
  assign blkCount   = cntReg;
  assign coreInit   = coreStart && initPend;
  assign coreAlgSel = selReg;
  assign memOwn     = busy;
  assign irq        = flagReg && ieReg;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    coreStart |=> !coreStart); // R5
  AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> flagReg); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(cntReg) && $stable(baseHi) && $stable(baseLo))); // R11
  AST_NO_FETCH_IN_CORE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> !strb.rdWord); // R5
endmodule

// File: rtl/sha_fetch_ctrl.sv
module sha_fetch_ctrl
  import sha_fetch_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    regAddr,
  input  logic          regWrEn,
  input  logic [7:0]    regWrData,
  output logic [7:0]    regRdData,
  output logic          memOwn,
  output logic [13:0]   memAddr,
  output logic          memRdEn,
  input  logic [31:0]   memRdData,
  output logic          memWrEn,
  output logic [31:0]   memWrData,
  output logic          coreStart,
  output logic          coreInit,
  output logic [2:0]    coreAlgSel,
  output logic [511:0]  coreBlock,
  input  logic [255:0]  coreState,
  input  logic          coreDone,
  output logic          irq
);
  dpStrobe_t         strb;
  logic [ADDR_W-1:6] baseAddr;
  logic [CNT_W-1:0]  blkCount;
  logic              wordLast, wbLast, blkLast;

  sha_fetch_control #(.CNT_W(CNT_W)) u_control (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .strb(strb), .baseAddr(baseAddr), .blkCount(blkCount),
    .wordLast(wordLast), .wbLast(wbLast), .blkLast(blkLast),
    .coreStart(coreStart), .coreInit(coreInit), .coreAlgSel(coreAlgSel), .coreDone(coreDone),
    .memOwn(memOwn), .irq(irq)
  );

  sha_fetch_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .baseAddr(baseAddr), .blkCount(blkCount),
    .memAddr(memAddr), .memRdEn(memRdEn), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrData(memWrData),
    .coreBlock(coreBlock), .coreState(coreState),
    .wordLast(wordLast), .wbLast(wbLast), .blkLast(blkLast)
  );

  AST_OWNED_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn || memWrEn) |-> memOwn); // R8
endmodule

// File: tb/sha_fetch_ctrl_bench.sv
module sha_fetch_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CORE_LAT   = 5;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic memOwn, memRdEn, memWrEn, coreStart, coreInit, irq;
  logic [13:0] memAddr;
  logic [31:0] memRdData = '0;
  logic [31:0] memWrData;
  logic [2:0] coreAlgSel;
  logic [511:0] coreBlock;
  logic [255:0] coreState = '0;
  logic coreDone = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int accNoOwn = 0;
  int rdInCore = 0;
  int doneCnt = 0;
  logic coreBusyTb = 1'b0;

  logic [13:0]  rdAddrQ[$];
  logic [511:0] blkQ[$];
  logic         initQ[$];
  logic [13:0]  wrAddrQ[$];
  logic [31:0]  wrDataQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sha_fetch_ctrl u_sha_fetch_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .memOwn(memOwn), .memAddr(memAddr), .memRdEn(memRdEn),
    .memRdData(memRdData), .memWrEn(memWrEn), .memWrData(memWrData),
    .coreStart(coreStart), .coreInit(coreInit), .coreAlgSel(coreAlgSel),
    .coreBlock(coreBlock), .coreState(coreState), .coreDone(coreDone), .irq(irq)
  );

  function automatic logic [31:0] memFn(input logic [13:0] a);
    return (32'h9E3779B9 * {18'b0, a}) ^ 32'h1234_5678 ^ {18'b0, a};
  endfunction

  function automatic logic [31:0] swapTb(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // memory model, core model and monitors
  always @(posedge clk) begin
    if (memRdEn) memRdData <= memFn(memAddr);
    if ((memRdEn || memWrEn) && !memOwn) accNoOwn <= accNoOwn + 1;
    if (memRdEn && coreBusyTb) rdInCore <= rdInCore + 1;
    if (memRdEn) rdAddrQ.push_back(memAddr);
    if (memWrEn) begin wrAddrQ.push_back(memAddr); wrDataQ.push_back(memWrData); end
    coreDone <= 1'b0;
    if (coreStart) begin
      blkQ.push_back(coreBlock);
      initQ.push_back(coreInit);
      coreBusyTb <= 1'b1;
      doneCnt <= CORE_LAT;
    end else if (coreBusyTb) begin
      if (doneCnt == 0) begin coreDone <= 1'b1; coreBusyTb <= 1'b0; end
      else doneCnt <= doneCnt - 1;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: run hung, act %0d cycles exp <= %0d", cycles, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: act %0h exp %0h", req, what, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic clearLogs();
    rdAddrQ.delete(); blkQ.delete(); initQ.delete(); wrAddrQ.delete(); wrDataQ.delete();
  endtask

  task automatic waitFlag();
    logic [7:0] s;
    forever begin
      @(negedge clk);
      regRd(3'd1, s);
      if (s[2]) break;
    end
  endtask

  task automatic setup(input int cnt, input logic [7:0] hi, input logic [7:0] lo);
    regWr(3'd2, 8'(cnt));
    regWr(3'd3, lo);
    regWr(3'd4, hi);
  endtask

  task automatic checkRun(input int cnt, input logic [7:0] hi, input logic [7:0] lo, input logic init);
    logic [13:0] baseW;
    logic [511:0] expBlk;
    logic ok;
    baseW = {hi, lo[7:6], 4'b0000};
    chk("R3", "read count", 512'(rdAddrQ.size()), 512'(16*(cnt+1)));
    ok = 1'b1;
    foreach (rdAddrQ[k]) if (rdAddrQ[k] !== 14'(baseW + 14'(k))) ok = 1'b0;
    chk("R3", "read addresses consecutive from base", 512'(ok), 512'(1));
    chk("R5", "core start pulses", 512'(blkQ.size()), 512'(cnt+1));
    for (int b = 0; b < blkQ.size(); b++) begin
      for (int w = 0; w < 16; w++)
        expBlk[511-32*w -: 32] = swapTb(memFn(14'(baseW + 14'(16*b + w))));
      chk("R4", $sformatf("block %0d contents", b), blkQ[b], expBlk);
      chk("R6", $sformatf("init flag block %0d", b), 512'(initQ[b]), 512'((b == 0) ? init : 1'b0));
    end
    chk("R5", "no read while core computing", 512'(rdInCore), 512'(0));
    chk("R8", "no access without ownership", 512'(accNoOwn), 512'(0));
  endtask

  task automatic runExec(input int cnt, input logic [7:0] hi, input logic [7:0] lo, input logic init);
    logic [7:0] s;
    setup(cnt, hi, lo);
    clearLogs();
    regWr(3'd0, {7'b0, 1'b1} | (init ? 8'h02 : 8'h00));
    regRd(3'd1, s);
    chk("R8", "busy after execute", 512'(s[0]), 512'(1));
    chk("R8", "memOwn after execute", 512'(memOwn), 512'(1));
    waitFlag();
    regRd(3'd1, s);
    chk("R9", "flag set, busy clear at end", 512'(s[2:0]), 512'(3'b100));
    chk("R8", "memOwn released", 512'(memOwn), 512'(0));
    checkRun(cnt, hi, lo, init);
    regWr(3'd1, 8'h04);
  endtask

  initial begin
    logic [7:0] d;
    logic [255:0] st;
    void'($urandom(32'd4049));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      regRd(3'(a), d);
      chk("R1", $sformatf("reg %0d reset", a), 512'(d), 512'(0));
    end
    chk("R1", "memOwn reset", 512'(memOwn), 512'(0));
    chk("R1", "irq reset", 512'(irq), 512'(0));

    // R2 register map
    regWr(3'd0, 8'h50);
    regRd(3'd0, d);
    chk("R2", "select readback", 512'(d), 512'(8'h50));
    chk("R2", "coreAlgSel", 512'(coreAlgSel), 512'(3'b101));
    chk("R8", "select write starts nothing", 512'(memOwn), 512'(0));
    regWr(3'd0, 8'h00);
    regWr(3'd3, 8'hFF);
    regRd(3'd3, d);
    chk("R2", "low base keeps bits 7:6", 512'(d), 512'(8'hC0));
    regWr(3'd4, 8'hA5);
    regRd(3'd4, d);
    chk("R2", "high base", 512'(d), 512'(8'hA5));
    regWr(3'd2, 8'h0B);
    regRd(3'd2, d);
    chk("R2", "count readback", 512'(d), 512'(8'h0B));

    // directed single block with reload
    runExec(0, 8'h03, 8'h40, 1'b1);
    regRd(3'd0, d);
    chk("R2", "action bits read zero", 512'(d[2:0]), 512'(0));

    // random runs
    for (int r = 0; r < 6; r++) begin
      int cnt;
      logic [7:0] hi, lo;
      logic ini;
      cnt = int'($urandom_range(0, 3));
      hi  = 8'($urandom);
      lo  = 8'($urandom);
      ini = 1'($urandom);
      runExec(cnt, hi, lo, ini);
    end

    // directed sixteen blocks without reload
    runExec(15, 8'h0F, 8'hC0, 1'b0);

    // R7 write-back
    for (int i = 0; i < 8; i++) st[255-32*i -: 32] = $urandom;
    coreState = st;
    setup(0, 8'h21, 8'h80);
    clearLogs();
    regWr(3'd0, 8'h04);
    waitFlag();
    chk("R7", "write count", 512'(wrAddrQ.size()), 512'(8));
    for (int i = 0; i < wrAddrQ.size(); i++) begin
      chk("R7", $sformatf("wb addr %0d", i), 512'(wrAddrQ[i]), 512'(14'({8'h21, 2'b10, 4'b0000} + i)));
      chk("R7", $sformatf("wb data %0d", i), 512'(wrDataQ[i]), 512'(swapTb(st[255-32*i -: 32])));
    end
    chk("R7", "no reads during write-back", 512'(rdAddrQ.size()), 512'(0));
    regWr(3'd1, 8'h04);

    // R11 execute and write-back together: execute only
    setup(0, 8'h10, 8'h00);
    clearLogs();
    regWr(3'd0, 8'h05);
    waitFlag();
    chk("R11", "no write-back with execute", 512'(wrAddrQ.size()), 512'(0));
    chk("R11", "execute ran", 512'(rdAddrQ.size()), 512'(16));
    regWr(3'd1, 8'h04);

    // R11 writes while busy ignored
    setup(2, 8'h44, 8'h40);
    clearLogs();
    regWr(3'd0, 8'h01);
    regWr(3'd2, 8'h0F);
    regWr(3'd4, 8'h77);
    regWr(3'd0, 8'h05);
    waitFlag();
    regRd(3'd2, d);
    chk("R11", "count unchanged", 512'(d), 512'(2));
    regRd(3'd4, d);
    chk("R11", "base unchanged", 512'(d), 512'(8'h44));
    checkRun(2, 8'h44, 8'h40, 1'b0);
    regWr(3'd1, 8'h04);
    repeat (40) @(negedge clk);
    regRd(3'd1, d);
    chk("R11", "no second command queued", 512'(d), 512'(0));
    chk("R11", "no write-back from busy write", 512'(wrAddrQ.size()), 512'(0));

    // R9 / R10 flag and interrupt
    regWr(3'd1, 8'h08);
    chk("R10", "irq low with flag clear", 512'(irq), 512'(0));
    runExec(1, 8'h02, 8'h00, 1'b1);
    regWr(3'd1, 8'h08);
    regWr(3'd2, 8'h00);
    clearLogs();
    regWr(3'd0, 8'h01);
    waitFlag();
    @(negedge clk);
    chk("R10", "irq with flag and enable", 512'(irq), 512'(1));
    regWr(3'd1, 8'h08);
    regRd(3'd1, d);
    chk("R9", "write 0 keeps flag", 512'(d), 512'(8'h0C));
    regWr(3'd1, 8'h00);
    chk("R10", "irq low with enable clear", 512'(irq), 512'(0));
    regWr(3'd1, 8'h0C);
    regRd(3'd1, d);
    chk("R9", "write 1 clears flag", 512'(d), 512'(8'h08));
    chk("R10", "irq low after clear", 512'(irq), 512'(0));

    summary();
    $finish;
  end
endmodule